// File: doc/BRIEF.md
# Memory Rail Sleep-State Sequencer

This block is the digital sequencer that sits beside the regulators of a memory power subsystem. It watches two sleep-control inputs, a supply-good flag, a thermal fault flag and a comparator flag that reports the main rail under roughly 200 mV. From these it drives enables for four rails: a high-voltage rail, a main rail, a reference rail and a termination rail. It also drives ramp-active flags for the two switching rails, two discharge controls and an undervoltage-protection arm signal. The analog regulation itself lies outside the block.

The two sleep inputs select between full operation, a sleep state and full shutdown. In the sleep state the termination rail is switched off and held in high impedance while the other three rails stay up. Start-up always ramps the high-voltage rail first and the main rail second. Both intervals, and the later arming of undervoltage protection, are timed by one prescaled tick counter. Shutdown first discharges in tracking mode. Once the main rail is reported low, it changes to fixed discharge together with high-rail discharge. A lost supply-good flag or a thermal fault forces every output low. When the fault clears, a fresh start-up begins.

Top module: `mem_rail_seq`

## Requirements
- R1: During reset and while the synchronized supply-good flag is low, every output is 0, and raising the active-high sleep input `s5_in` does not start a ramp.
- R2: In full operation (`s3_in`=1, `s5_in`=1, ramps finished), `en_hi`, `en_main`, `en_vref` and `en_term` are 1, `term_hiz` is 0, and no discharge output is 1.
- R3: In the sleep state (`s3_in`=0, `s5_in`=1, ramps finished), `en_term` is 0 and `term_hiz` is 1, while `en_hi`, `en_main` and `en_vref` stay 1.
- R4: On the third rising clock edge after `s5_in` rises, `en_hi` and `ramp_hi` become 1 for HI_TICKS*PRESCALE cycles. Then `ramp_main` is 1 with `en_hi`, `en_main` and `en_vref` for MAIN_TICKS*PRESCALE cycles, and `en_main` never rises unless `en_hi` was already 1.
- R5: `uvp_arm` rises exactly UVP_TICKS*PRESCALE cycles after the ramp start of R4, and it is never 1 while either ramp flag is 1.
- R6: A fall of `s5_in` during either ramp or in operation reaches tracking discharge on the third rising edge: `dis_track`=1 with all enables and ramp flags 0.
- R7: In tracking discharge, a high `main_low` moves the block on the third rising edge to `dis_fixed`=1 with `dis_hi`=1 and `dis_track`=0. In any other state `main_low` has no effect.
- R8: A rise of `s5_in` during either discharge phase starts a fresh ramp, as in R4.
- R9: A high `therm_flt` forces every output to 0 on the third rising edge. When it is released with `s5_in` high, a fresh ramp starts on the third rising edge.
- R10: The loss of `por_ok` forces every output to 0 on the third rising edge. When it returns with `s5_in` high, a fresh ramp starts on the third rising edge.
- R11: A change of `s3_in` in operation reaches `en_term` and `term_hiz` on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s3_in | input | 1 | Sleep control: 0 selects the sleep state while `s5_in` is 1 |
| s5_in | input | 1 | Sleep control: 0 selects full shutdown |
| por_ok | input | 1 | Supply power-on-reset good |
| therm_flt | input | 1 | Thermal shutdown request |
| main_low | input | 1 | Main rail below about 200 mV |
| en_hi | output | 1 | High-voltage rail enable |
| en_main | output | 1 | Main rail enable |
| en_vref | output | 1 | Reference rail enable |
| en_term | output | 1 | Termination rail enable |
| term_hiz | output | 1 | Termination rail held in high impedance |
| ramp_hi | output | 1 | High-voltage rail soft-start active |
| ramp_main | output | 1 | Main rail soft-start active |
| dis_track | output | 1 | Tracking discharge of main and termination rails |
| dis_fixed | output | 1 | Fixed discharge of main and termination rails |
| dis_hi | output | 1 | High-voltage rail discharge |
| uvp_arm | output | 1 | Undervoltage protection armed |

## Verification
The fall of `s5_in` can land in the same cycle as the tick that ends a ramp phase or arms undervoltage protection. Abort and phase advance then compete for the next state. The bench restarts the ramp many times and drops `s5_in` at a random cycle offset. The offsets cover the exact phase boundaries, so the two sometimes coincide. Each time it expects the phase given by the offset two edges later and tracking discharge on the third edge, whatever the timer was about to do.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_RAMP_HI   = 3'd1,
    ST_RAMP_MAIN = 3'd2,
    ST_ACTIVE    = 3'd3,
    ST_DIS_TRK   = 3'd4,
    ST_DIS_FIX   = 3'd5
  } mrs_state_e;

  typedef struct packed {
    logic en_hi;
    logic en_main;
    logic en_vref;
    logic en_term;
    logic term_hiz;
    logic ramp_hi;
    logic ramp_main;
    logic dis_track;
    logic dis_fixed;
    logic dis_hi;
    logic uvp_arm;
  } mrs_ctl_t;

endpackage

// File: rtl/mrs_sync.sv
module mrs_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic meta_q;
      logic stab_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= async_in[gi];
          stab_q <= meta_q;
        end
      end

      assign sync_out[gi] = stab_q;
    end
  endgenerate

endmodule

// File: rtl/mrs_timer.sv
module mrs_timer #(
  parameter int PRESCALE   = 4,
  parameter int HI_TICKS   = 4,
  parameter int MAIN_TICKS = 8,
  parameter int UVP_TICKS  = 14,
  localparam int SEG_MAX   = (HI_TICKS > MAIN_TICKS) ? HI_TICKS : MAIN_TICKS,
  localparam int SW        = $clog2(SEG_MAX + 1),
  localparam int RW        = $clog2(UVP_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run_en,
  input  logic          seg_clr,
  output logic          tick,
  output logic [SW-1:0] seg_cnt,
  output logic          uvp_due
);

  localparam logic [SW-1:0] SEG_TOP = SW'(SEG_MAX);
  localparam logic [RW-1:0] RUN_TOP = RW'(UVP_TICKS);

  logic [SW-1:0] seg_q, seg_d;
  logic [RW-1:0] run_q, run_d;
  logic          seg_en, run_en_cnt;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] PRE_TOP = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q, pre_d;
      logic          pre_en;

      always_comb begin
        pre_en = restart || run_en;
        pre_d  = pre_q;
        if (restart)              pre_d = '0;
        else if (pre_q == PRE_TOP) pre_d = '0;
        else                       pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end

      assign tick = run_en && !restart && (pre_q == PRE_TOP);

      // R4: a tick never repeats on consecutive cycles when prescaling
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_nopre
      assign tick = run_en && !restart;
    end
  endgenerate

  always_comb begin
    seg_en = restart || seg_clr || tick;
    seg_d  = seg_q;
    if (restart || seg_clr)  seg_d = '0;
    else if (seg_q != SEG_TOP) seg_d = seg_q + 1'b1;
  end

  always_comb begin
    run_en_cnt = restart || (tick && (run_q != RUN_TOP));
    run_d      = restart ? '0 : run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      run_q <= '0;
    end else begin
      if (seg_en)     seg_q <= seg_d;
      if (run_en_cnt) run_q <= run_d;
    end
  end

  assign seg_cnt = seg_q;
  assign uvp_due = (run_q == RUN_TOP);

  // R5: the arm counter saturates and never passes its limit
  a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_TOP);

  // R5: once due, the arm flag holds until a new start-up
  a_r5_due_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (uvp_due && !restart) |=> uvp_due);

endmodule

// File: rtl/mrs_fsm.sv
module mrs_fsm
  import mrs_pkg::*;
#(
  parameter int HI_TICKS   = 4,
  parameter int MAIN_TICKS = 8,
  parameter int SW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s5_s,
  input  logic          por_s,
  input  logic          therm_s,
  input  logic          low_s,
  input  logic          tick,
  input  logic [SW-1:0] seg_cnt,
  output mrs_state_e    state,
  output logic          restart,
  output logic          run_en,
  output logic          seg_clr
);

  localparam logic [SW-1:0] HI_LAST   = SW'(HI_TICKS - 1);
  localparam logic [SW-1:0] MAIN_LAST = SW'(MAIN_TICKS - 1);

  mrs_state_e state_q, state_d;
  logic       hi_done, main_done, fault;

  assign hi_done   = tick && (seg_cnt == HI_LAST);
  assign main_done = tick && (seg_cnt == MAIN_LAST);
  assign fault     = !por_s || therm_s;

  always_comb begin
    state_d = state_q;
    if (fault) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:       state_d = s5_s ? ST_RAMP_HI : ST_DIS_TRK;
        ST_RAMP_HI: begin
          if (!s5_s)        state_d = ST_DIS_TRK;
          else if (hi_done) state_d = ST_RAMP_MAIN;
        end
        ST_RAMP_MAIN: begin
          if (!s5_s)          state_d = ST_DIS_TRK;
          else if (main_done) state_d = ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (!s5_s) state_d = ST_DIS_TRK;
        end
        ST_DIS_TRK: begin
          if (s5_s)       state_d = ST_RAMP_HI;
          else if (low_s) state_d = ST_DIS_FIX;
        end
        ST_DIS_FIX: begin
          if (s5_s) state_d = ST_RAMP_HI;
        end
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign restart = (state_d == ST_RAMP_HI) && (state_q != ST_RAMP_HI);
  assign seg_clr = (state_d != state_q);
  assign run_en  = (state_q == ST_RAMP_HI) || (state_q == ST_RAMP_MAIN) ||
                   (state_q == ST_ACTIVE);
  assign state   = state_q;

  // R9 R10: a fault seen by the synchronizers empties the sequencer next cycle
  a_r9_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (state_q == ST_OFF));

  // R4: the main ramp is entered only from the high-rail ramp
  a_r4_main_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RAMP_MAIN) && ($past(state_q) != ST_RAMP_MAIN))
      |-> ($past(state_q) == ST_RAMP_HI));

  // R7: fixed discharge is entered only from tracking discharge
  a_r7_fix_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DIS_FIX) && ($past(state_q) != ST_DIS_FIX))
      |-> ($past(state_q) == ST_DIS_TRK));

  // R6: losing the run request leaves every powered state
  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!s5_s && run_en) |=> !run_en);

endmodule

// File: rtl/mrs_outdec.sv
module mrs_outdec
  import mrs_pkg::*;
(
  input  mrs_state_e state,
  input  logic       s3_s,
  input  logic       uvp_due,
  output mrs_ctl_t   ctl
);

  logic main_up;

  always_comb begin
    ctl     = '0;
    main_up = (state == ST_RAMP_MAIN) || (state == ST_ACTIVE);
    unique case (state)
      ST_RAMP_HI: begin
        ctl.en_hi   = 1'b1;
        ctl.ramp_hi = 1'b1;
      end
      ST_RAMP_MAIN: begin
        ctl.en_hi     = 1'b1;
        ctl.ramp_main = 1'b1;
      end
      ST_ACTIVE: begin
        ctl.en_hi   = 1'b1;
        ctl.en_term = s3_s;
        ctl.uvp_arm = uvp_due;
      end
      ST_DIS_TRK: begin
        ctl.dis_track = 1'b1;
      end
      ST_DIS_FIX: begin
        ctl.dis_fixed = 1'b1;
        ctl.dis_hi    = 1'b1;
      end
      default: ctl = '0;
    endcase
    ctl.en_main  = main_up;
    ctl.en_vref  = main_up;
    ctl.term_hiz = main_up && !ctl.en_term;
  end

endmodule

// File: rtl/mem_rail_seq.sv
module mem_rail_seq
  import mrs_pkg::*;
#(
  parameter int PRESCALE   = 4,
  parameter int HI_TICKS   = 4,
  parameter int MAIN_TICKS = 8,
  parameter int UVP_TICKS  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s3_in,
  input  logic s5_in,
  input  logic por_ok,
  input  logic therm_flt,
  input  logic main_low,
  output logic en_hi,
  output logic en_main,
  output logic en_vref,
  output logic en_term,
  output logic term_hiz,
  output logic ramp_hi,
  output logic ramp_main,
  output logic dis_track,
  output logic dis_fixed,
  output logic dis_hi,
  output logic uvp_arm
);

  localparam int NSYNC   = 5;
  localparam int SEG_MAX = (HI_TICKS > MAIN_TICKS) ? HI_TICKS : MAIN_TICKS;
  localparam int SW      = $clog2(SEG_MAX + 1);

  // reset: asserted at once, released on the second clock edge
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [NSYNC-1:0] raw_in, syn;
  logic             s3_s, s5_s, por_s, therm_s, low_s;

  assign raw_in = {main_low, therm_flt, por_ok, s5_in, s3_in};
  assign {low_s, therm_s, por_s, s5_s, s3_s} = syn;

  mrs_sync #(.WIDTH(NSYNC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_q),
    .async_in (raw_in),
    .sync_out (syn)
  );

  logic          tick, restart, run_en, seg_clr, uvp_due;
  logic [SW-1:0] seg_cnt;
  mrs_state_e    state;
  mrs_ctl_t      ctl;

  mrs_timer #(
    .PRESCALE   (PRESCALE),
    .HI_TICKS   (HI_TICKS),
    .MAIN_TICKS (MAIN_TICKS),
    .UVP_TICKS  (UVP_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_q),
    .restart (restart),
    .run_en  (run_en),
    .seg_clr (seg_clr),
    .tick    (tick),
    .seg_cnt (seg_cnt),
    .uvp_due (uvp_due)
  );

  mrs_fsm #(
    .HI_TICKS   (HI_TICKS),
    .MAIN_TICKS (MAIN_TICKS),
    .SW         (SW)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_q),
    .s5_s    (s5_s),
    .por_s   (por_s),
    .therm_s (therm_s),
    .low_s   (low_s),
    .tick    (tick),
    .seg_cnt (seg_cnt),
    .state   (state),
    .restart (restart),
    .run_en  (run_en),
    .seg_clr (seg_clr)
  );

  mrs_outdec u_dec (
    .state   (state),
    .s3_s    (s3_s),
    .uvp_due (uvp_due),
    .ctl     (ctl)
  );

  assign en_hi     = ctl.en_hi;
  assign en_main   = ctl.en_main;
  assign en_vref   = ctl.en_vref;
  assign en_term   = ctl.en_term;
  assign term_hiz  = ctl.term_hiz;
  assign ramp_hi   = ctl.ramp_hi;
  assign ramp_main = ctl.ramp_main;
  assign dis_track = ctl.dis_track;
  assign dis_fixed = ctl.dis_fixed;
  assign dis_hi    = ctl.dis_hi;
  assign uvp_arm   = ctl.uvp_arm;

  // R4: the main rail only comes up after the high rail was on
  a_r4_hi_first: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(en_main) |-> $past(en_hi));

  // R5: protection is never armed while a ramp runs
  a_r5_no_arm_ramp: assert property (@(posedge clk) disable iff (!rst_q)
    uvp_arm |-> !(ramp_hi || ramp_main));

  // R6 R7: discharge and rail enables are never on together
  a_r6_dis_vs_en: assert property (@(posedge clk) disable iff (!rst_q)
    (dis_track || dis_fixed) |-> !(en_hi || en_main || en_term));

  // R7: the two discharge modes are exclusive
  a_r7_dis_excl: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({dis_track, dis_fixed}));

  // R11: the termination enable follows the sleep input through two flops
  a_r11_term_sync: assert property (@(posedge clk) disable iff (!rst_q)
    en_term |-> $past(s3_in, 2));

endmodule

// File: tb/test_mem_rail_seq.sv
module test_mem_rail_seq;

  localparam int PRE  = 4;
  localparam int HI   = 4;
  localparam int MAIN = 8;
  localparam int UVP  = 14;

  localparam int PH_OFF = 0, PH_RHI = 1, PH_RMAIN = 2, PH_ACT = 3,
                 PH_ACTU = 4, PH_DTRK = 5, PH_DFIX = 6;

  logic clk = 1'b0;
  logic rst_n, s3_in, s5_in, por_ok, therm_flt, main_low;
  logic en_hi, en_main, en_vref, en_term, term_hiz, ramp_hi, ramp_main;
  logic dis_track, dis_fixed, dis_hi, uvp_arm;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  mem_rail_seq #(
    .PRESCALE(PRE), .HI_TICKS(HI), .MAIN_TICKS(MAIN), .UVP_TICKS(UVP)
  ) i_mem_rail_seq (
    .clk(clk), .rst_n(rst_n), .s3_in(s3_in), .s5_in(s5_in),
    .por_ok(por_ok), .therm_flt(therm_flt), .main_low(main_low),
    .en_hi(en_hi), .en_main(en_main), .en_vref(en_vref), .en_term(en_term),
    .term_hiz(term_hiz), .ramp_hi(ramp_hi), .ramp_main(ramp_main),
    .dis_track(dis_track), .dis_fixed(dis_fixed), .dis_hi(dis_hi),
    .uvp_arm(uvp_arm)
  );

  // order: en_hi en_main en_vref en_term term_hiz ramp_hi ramp_main
  //        dis_track dis_fixed dis_hi uvp_arm
  function automatic logic [10:0] exp_vec(int ph, logic s3);
    logic [10:0] v = '0;
    case (ph)
      PH_RHI:   begin v[10] = 1; v[5] = 1; end
      PH_RMAIN: begin v[10] = 1; v[9] = 1; v[8] = 1; v[6] = 1; v[4] = 1; end
      PH_ACT, PH_ACTU: begin
        v[10] = 1; v[9] = 1; v[8] = 1; v[7] = s3; v[6] = !s3;
        v[0] = (ph == PH_ACTU);
      end
      PH_DTRK:  v[3] = 1;
      PH_DFIX:  begin v[2] = 1; v[1] = 1; end
      default:  v = '0;
    endcase
    return v;
  endfunction

  function automatic int phase_at(int t);
    if (t < HI * PRE)          return PH_RHI;
    if (t < (HI + MAIN) * PRE) return PH_RMAIN;
    if (t < UVP * PRE)         return PH_ACT;
    return PH_ACTU;
  endfunction

  function automatic logic [10:0] act_vec();
    return {en_hi, en_main, en_vref, en_term, term_hiz, ramp_hi, ramp_main,
            dis_track, dis_fixed, dis_hi, uvp_arm};
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(int ph, logic s3, string req);
    logic [10:0] e = exp_vec(ph, s3);
    logic [10:0] a = act_vec();
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, a, e);
    end
  endtask

  // checks a full start-up from the negedge right after the ramp-start edge
  task automatic check_rampup(logic s3, string req);
    chk(PH_RHI, s3, req);
    step(HI * PRE - 1);           chk(PH_RHI, s3, req);
    step(1);                      chk(PH_RMAIN, s3, req);
    step(MAIN * PRE - 1);         chk(PH_RMAIN, s3, req);
    step(1);                      chk(PH_ACT, s3, req);
    step((UVP - HI - MAIN) * PRE - 1); chk(PH_ACT, s3, "R5");
    step(1);                      chk(PH_ACTU, s3, "R5");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    rst_n = 1'b0; s3_in = 1'b1; s5_in = 1'b0; por_ok = 1'b0;
    therm_flt = 1'b0; main_low = 1'b0;
    step(3);
    chk(PH_OFF, 1'b1, "R1");                 // reset state
    rst_n = 1'b1;
    s5_in = 1'b1;
    step(12);
    chk(PH_OFF, 1'b1, "R1");                 // no start without supply good
    chk(PH_OFF, 1'b1, "R10");

    // R10 supply good arrives: fresh start, full S0 bring-up
    por_ok = 1'b1;
    step(2); chk(PH_OFF, 1'b1, "R10");
    step(1);
    check_rampup(1'b1, "R4");
    chk(PH_ACTU, 1'b1, "R2");

    // R11 / R3: sleep entry through the synchronizer
    s3_in = 1'b0;
    step(1); chk(PH_ACTU, 1'b1, "R11");
    step(1); chk(PH_ACTU, 1'b0, "R11");
    chk(PH_ACTU, 1'b0, "R3");

    // R7: main_low ignored while operating
    main_low = 1'b1;
    step(5); chk(PH_ACTU, 1'b0, "R7");
    main_low = 1'b0;
    s3_in = 1'b1;
    step(3); chk(PH_ACTU, 1'b1, "R2");

    // R6: shutdown into tracking discharge
    s5_in = 1'b0;
    step(2); chk(PH_ACTU, 1'b1, "R6");
    step(1); chk(PH_DTRK, 1'b1, "R6");
    step(6); chk(PH_DTRK, 1'b1, "R6");

    // R7: main rail low switches to fixed discharge
    main_low = 1'b1;
    step(2); chk(PH_DTRK, 1'b1, "R7");
    step(1); chk(PH_DFIX, 1'b1, "R7");
    main_low = 1'b0;
    step(4); chk(PH_DFIX, 1'b1, "R7");

    // R8: restart from fixed discharge
    s5_in = 1'b1;
    step(2); chk(PH_DFIX, 1'b1, "R8");
    step(1); chk(PH_RHI, 1'b1, "R8");

    // random abort points sweeping the ramp boundaries (R6, R8)
    for (int it = 0; it < 24; it++) begin
      int  k;
      logic s3r;
      logic lowr;
      k    = $urandom_range(0, UVP * PRE + 6);
      s3r  = 1'($urandom_range(0, 1));
      lowr = 1'($urandom_range(0, 1));
      step(k);
      chk(phase_at(k), s3_in, "R4");
      s5_in = 1'b0;
      step(2); chk(phase_at(k + 2), s3_in, "R6");
      step(1); chk(PH_DTRK, s3_in, "R6");
      main_low = lowr;
      s3_in = s3r;
      step(3); chk(lowr ? PH_DFIX : PH_DTRK, s3_in, "R7");
      main_low = 1'b0;
      s5_in = 1'b1;
      step(3); chk(PH_RHI, s3_in, "R8");
    end

    // R9: thermal fault during operation, then a fresh start
    step(UVP * PRE);
    chk(PH_ACTU, s3_in, "R5");
    therm_flt = 1'b1;
    step(2); chk(PH_ACTU, s3_in, "R9");
    step(1); chk(PH_OFF, s3_in, "R9");
    step(8); chk(PH_OFF, s3_in, "R9");
    therm_flt = 1'b0;
    step(2); chk(PH_OFF, s3_in, "R9");
    step(1);
    check_rampup(s3_in, "R9");

    // R10: supply lost mid-ramp
    s5_in = 1'b0;
    step(3); chk(PH_DTRK, s3_in, "R6");
    s5_in = 1'b1;
    step(3 + 5);
    por_ok = 1'b0;
    step(2); chk(phase_at(7), s3_in, "R10");
    step(1); chk(PH_OFF, s3_in, "R10");
    por_ok = 1'b1;
    step(3);
    chk(PH_RHI, s3_in, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule